// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block turns the digital decisions of a buck converter's voltage loop into two gate enables, one for the high-side switch and one for the low-side switch. A one-tick start pulse opens every switching period and turns the high side on. A reset request from the loop comparator ends the on-time. Either gate is turned on only after the other one has been off for a programmed number of clock ticks, so the two switches are never on together.

The block also applies two protection rules. The first is a startup rule: the low-side switch stays off until the high side has been started at least once, or until the soft-start flag reports that the ramp is past its threshold. This keeps the low side from pulling the output down while it is still rising. The second rule covers full-duty operation. Without a reset request the high side stays on across period boundaries, but once it has run through a set number of whole periods it is cut off at the midpoint of the last one. The low side then conducts for the rest of that period, which recharges the bootstrap supply.

The global disable input drops both gates and withdraws the startup permission.

Top module: `buck_gate_seq`

## Requirements
- R1: While reset is applied, and directly after it is released, both `hs_en` and `ls_en` are low.
- R2: `ls_en` stays low until either a start pulse has been accepted or `ss_done` is high. The first start pulse after reset turns `hs_en` on one tick after the edge that sampled it, provided the low side was off.
- R3: A start pulse sets the on request. A reset request sampled r ticks after the start edge clears it, and `hs_en` falls on edge r+1.
- R4: When a start pulse and a reset request are sampled on the same edge, the start pulse wins and the high side turns on.
- R5: `hs_en` and `ls_en` are never high together.
- R6: In both directions, exactly `DEAD_TICKS` sampled ticks with both gates low separate one gate falling from the other rising.
- R7: A period with no reset request leaves `hs_en` high through the next start pulse, with no low gap.
- R8: In the `MAX_ON_CYCLES`-th consecutive full-on period, the on request is cleared on the edge after the period counter reaches `PERIOD_TICKS/2`, so `hs_en` falls `PERIOD_TICKS/2 + 2` edges after that period's start edge.
- R9: After this forced cut-off, `ls_en` rises after the dead time and stays high until the next start pulse.
- R10: Any period in which the high side is turned off clears the count of consecutive full-on periods, so a later full-duty run again lasts `MAX_ON_CYCLES` periods.
- R11: `drv_disable` pulls both gates low on the next edge, blocks start pulses while it is high, and clears the startup permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_set | input | 1 | One-tick pulse that opens a switching period |
| pwm_rst_req | input | 1 | Loop comparator request that ends the on-time |
| ss_done | input | 1 | Soft-start ramp is above its threshold |
| drv_disable | input | 1 | Forces both gates off and clears startup permission |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
Each internal fault shows up as a shift in the tick at which a gate edge occurs, so the bench measures every gate edge against the start edge of its own period. A consecutive-on count that does not clear shows up as an early cut-off during a later full-duty run. A wrong midpoint marker moves the `hs_en` fall inside the final period. A startup flag that is never cleared lets `ls_en` rise right after a disable, while soft-start is still low. An error in the dead-time counter makes a gap of the wrong length within one period of the gate change.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  // Gate requests handed from the latch stage to the non-overlap stage
  typedef struct packed {
    logic hs;
    logic ls;
  } gate_req_t;
endpackage

// File: rtl/buck_period_timer.sv
module buck_period_timer #(
  parameter int PERIOD_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  output logic mid_mark
);
  localparam int PW = $clog2(PERIOD_TICKS);
  localparam logic [PW-1:0] LAST = PW'(PERIOD_TICKS - 1);
  localparam logic [PW-1:0] HALF = PW'(PERIOD_TICKS / 2);

  logic [PW-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                tick_cnt <= LAST;
    else if (cyc_start)        tick_cnt <= '0;
    else if (tick_cnt != LAST) tick_cnt <= tick_cnt + PW'(1);
  end

  assign mid_mark = (tick_cnt == HALF);

  // R8
  mid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_mark |=> !mid_mark);
endmodule

// File: rtl/buck_pwm_latch.sv
module buck_pwm_latch
  import buck_seq_pkg::*;
#(
  parameter int MAX_ON_CYCLES = 20
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      kill,
  input  logic      start,
  input  logic      stop_req,
  input  logic      mid_mark,
  input  logic      ss_done,
  output gate_req_t req,
  output logic      ls_allowed
);
  localparam int OW = $clog2(MAX_ON_CYCLES + 1);
  localparam logic [OW-1:0] LIMIT = OW'(MAX_ON_CYCLES);

  logic          on_q;
  logic          tried_q;
  logic [OW-1:0] run_cnt;
  logic          refresh_cut;

  assign refresh_cut = (run_cnt == LIMIT) && mid_mark;

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      on_q    <= 1'b0;
      tried_q <= 1'b0;
      run_cnt <= '0;
    end else if (start) begin
      on_q    <= 1'b1;
      tried_q <= 1'b1;
      if (!on_q)                run_cnt <= OW'(1);
      else if (run_cnt != LIMIT) run_cnt <= run_cnt + OW'(1);
    end else if (on_q && (stop_req || refresh_cut)) begin
      on_q    <= 1'b0;
      run_cnt <= '0;
    end
  end

  assign ls_allowed = tried_q || ss_done;
  assign req.hs     = on_q;
  assign req.ls     = !on_q && ls_allowed;

  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LIMIT);

  // R11
  kill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!on_q && !tried_q));

  // R4
  start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !kill) |=> on_q);
endmodule

// File: rtl/buck_dead_time.sv
module buck_dead_time
  import buck_seq_pkg::*;
#(
  parameter int DEAD_TICKS = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      kill,
  input  gate_req_t req,
  output logic      hs_en,
  output logic      ls_en
);
  localparam int DW = $clog2(DEAD_TICKS + 1);
  localparam logic [DW-1:0] GAP = DW'(DEAD_TICKS);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_en   <= 1'b0;
      ls_en   <= 1'b0;
      gap_cnt <= GAP;
    end else if (kill) begin
      hs_en   <= 1'b0;
      ls_en   <= 1'b0;
      gap_cnt <= ONE;
    end else if (hs_en && !req.hs) begin
      hs_en   <= 1'b0;
      gap_cnt <= ONE;
    end else if (ls_en && !req.ls) begin
      ls_en   <= 1'b0;
      gap_cnt <= ONE;
    end else if (!hs_en && !ls_en) begin
      if (gap_cnt != GAP) gap_cnt <= gap_cnt + ONE;
      else if (req.hs)    hs_en   <= 1'b1;
      else if (req.ls)    ls_en   <= 1'b1;
    end
  end

  // R5
  gate_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  // R6
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(!ls_en));

  // R6
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> $past(!hs_en));
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import buck_seq_pkg::*;
#(
  parameter int PERIOD_TICKS  = 16,
  parameter int MAX_ON_CYCLES = 20,
  parameter int DEAD_TICKS    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_set,
  input  logic pwm_rst_req,
  input  logic ss_done,
  input  logic drv_disable,
  output logic hs_en,
  output logic ls_en
);
  gate_req_t gate_req;
  logic      mid_mark;
  logic      ls_allowed;

  buck_period_timer #(.PERIOD_TICKS(PERIOD_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (pwm_set),
    .mid_mark  (mid_mark)
  );

  buck_pwm_latch #(.MAX_ON_CYCLES(MAX_ON_CYCLES)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill       (drv_disable),
    .start      (pwm_set),
    .stop_req   (pwm_rst_req),
    .mid_mark   (mid_mark),
    .ss_done    (ss_done),
    .req        (gate_req),
    .ls_allowed (ls_allowed)
  );

  buck_dead_time #(.DEAD_TICKS(DEAD_TICKS)) u_dead (
    .clk   (clk),
    .rst_n (rst_n),
    .kill  (drv_disable),
    .req   (gate_req),
    .hs_en (hs_en),
    .ls_en (ls_en)
  );

  // R2
  ls_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_en |-> $past(ls_allowed));

  // R11
  disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_disable |=> (!hs_en && !ls_en));
endmodule

// File: tb/buck_gate_seq_test.sv
module buck_gate_seq_test;
  localparam int P    = 16;
  localparam int MAXC = 20;
  localparam int DT   = 2;
  localparam int HALF = P / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_set = 1'b0;
  logic pwm_rst_req = 1'b0;
  logic ss_done = 1'b0;
  logic drv_disable = 1'b0;
  logic hs_en, ls_en;

  int checks = 0;
  int errors = 0;
  int tick_no = 0;
  int hs_rise = -1, hs_fall = -1, ls_rise = -1, ls_fall = -1;
  int hs_fall_n = 0;
  int overlap_n = 0;
  logic hs_q = 1'b0, ls_q = 1'b0;

  buck_gate_seq #(.PERIOD_TICKS(P), .MAX_ON_CYCLES(MAXC), .DEAD_TICKS(DT)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_set(pwm_set), .pwm_rst_req(pwm_rst_req),
    .ss_done(ss_done), .drv_disable(drv_disable), .hs_en(hs_en), .ls_en(ls_en)
  );

  always #2 clk = ~clk;

  always @(posedge clk) tick_no <= tick_no + 1;

  always @(negedge clk) begin
    if (hs_en && !hs_q) hs_rise = tick_no;
    if (!hs_en && hs_q) begin hs_fall = tick_no; hs_fall_n++; end
    if (ls_en && !ls_q) ls_rise = tick_no;
    if (!ls_en && ls_q) ls_fall = tick_no;
    if (hs_en && ls_en) overlap_n++;
    hs_q = hs_en;
    ls_q = ls_en;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    if (tick_no > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", tick_no);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // One switching period; r = tick of the reset request (0 = none).
  task automatic run_cycle(input int r, input bit both, output int t0);
    @(negedge clk);
    pwm_set = 1'b1;
    if (both) pwm_rst_req = 1'b1;
    @(negedge clk);
    pwm_set = 1'b0;
    pwm_rst_req = 1'b0;
    t0 = tick_no;
    if (r > 0) begin
      while (tick_no < t0 + r - 1) @(negedge clk);
      pwm_rst_req = 1'b1;
      @(negedge clk);
      pwm_rst_req = 1'b0;
    end
    while (tick_no < t0 + P - 2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check("R1 hs in reset", hs_en, 0);
    check("R1 ls in reset", ls_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 hs after reset", hs_en, 0);
    check("R1 ls after reset", ls_en, 0);
  endtask

  task automatic t_startup_hold();
    int seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (ls_en) seen++;
    end
    check("R2 ls held before start", seen, 0);
  endtask

  task automatic t_first_cycles();
    int t0;
    run_cycle(5, 1'b0, t0);
    check("R2 first hs rise", hs_rise - t0, 1);
    check("R3 hs fall after reset req", hs_fall - t0, 6);
    check("R6 hs->ls gap", ls_rise - hs_fall, DT);
    run_cycle(8, 1'b0, t0);
    check("R6 ls fall on start", ls_fall - t0, 1);
    check("R6 ls->hs gap", hs_rise - ls_fall, DT);
    check("R3 hs fall at r=8", hs_fall - t0, 9);
  endtask

  task automatic t_coincident();
    int t0;
    run_cycle(0, 1'b1, t0);
    check("R4 start wins over reset", hs_rise - t0, 1 + DT);
    run_cycle(4, 1'b0, t0);
    check("R3 hs fall after carried-on cycle", hs_fall - t0, 5);
  endtask

  // Full-duty run of MAXC periods ending in the forced cut-off.
  task automatic full_run(input string tag);
    int t0;
    int n0;
    n0 = hs_fall_n;
    for (int i = 1; i < MAXC; i++) run_cycle(0, 1'b0, t0);
    check({"R7 no hs drop in run ", tag}, hs_fall_n - n0, 0);
    run_cycle(0, 1'b0, t0);
    check({"R8 forced cut tick ", tag}, hs_fall - t0, HALF + 2);
    check({"R9 ls after cut ", tag}, ls_rise - hs_fall, DT);
    check({"R9 ls held to period end ", tag}, {30'd0, ls_en, hs_en}, 2);
  endtask

  task automatic t_timeout();
    full_run("A");
  endtask

  task automatic t_count_clear();
    int t0;
    for (int i = 0; i < 10; i++) run_cycle(0, 1'b0, t0);
    run_cycle(6, 1'b0, t0);
    check("R10 cut by request", hs_fall - t0, 7);
    full_run("R10");
  endtask

  task automatic t_disable();
    int t0;
    int seen = 0;
    @(negedge clk);
    pwm_set = 1'b1;
    @(negedge clk);
    pwm_set = 1'b0;
    t0 = tick_no;
    repeat (6) @(negedge clk);
    drv_disable = 1'b1;
    @(negedge clk);
    check("R11 both low after disable", {30'd0, hs_en, ls_en}, 0);
    pwm_set = 1'b1;
    @(negedge clk);
    pwm_set = 1'b0;
    repeat (6) @(negedge clk);
    check("R11 start ignored while disabled", hs_en, 0);
    drv_disable = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (ls_en) seen++;
    end
    check("R11 permission cleared", seen, 0);
    ss_done = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 ls via soft-start", ls_en, 1);
  endtask

  initial begin
    t_reset();
    t_startup_hold();
    t_first_cycles();
    t_coincident();
    t_timeout();
    t_count_clear();
    t_disable();
    check("R5 overlap count", overlap_n, 0);
    summary();
    $finish;
  end
endmodule